// File: doc/BRIEF.md
# Pulse-Width Trimming and Resync Mask

This block cleans up a raw pulse-width-modulated sample stream before it drives a carrier modulator. Each sample period starts with a short guard window and ends with a cut-off window, both taken from timing strobes that the ramp generator produces. In a trimming mode the output pulse is stretched to at least the guard window. It is cut off no later than the start of the cut-off window. Once it falls after the guard window it cannot rise again until the next guard window. This removes very narrow high and low pulses that would otherwise widen the spectrum the link has to carry.

A 2-bit mode input selects between two trimming references and a transparent pass-through. Every input is brought onto a fast sampling clock through a synchronizer, so the result reaches the output a fixed number of clock edges later in every mode. A new mode is taken on only at the start of a sample period, which is marked by the rising edge of the Q strobe. A pulse in progress is therefore never cut short by a mode change.

Top module: `pwm_trim_mask`

## Requirements
- R1: After reset `pwm_out` is low and the active mode is trim-on-Q (code 00). Until the first rising edge of `win_q`, a high `pwm_raw` with `win_r` high and `win_q` low leaves `pwm_out` low.
- R2: In a trimming mode (code 00 uses `win_q` as guard and `win_r` as cut-off; code 01 uses `win_qn` as guard and `win_s` as cut-off), `pwm_out` is high while the guard window is high, even if `pwm_raw` is low. A raw pulse shorter than the guard window leaves as exactly the guard width.
- R3: In a trimming mode, `pwm_out` is low while the guard window is low and the cut-off window is low. A raw pulse that runs past the start of the cut-off window is truncated there. The guard window wins when both apply.
- R4: In a trimming mode, once `pwm_out` is low with the guard window low, it stays low until the guard window rises again. A narrow raw high pulse after the guard window never reaches the output, and a narrow raw low gap ends the pulse.
- R5: Mode codes 10 and 11 both bypass trimming: `pwm_out` reproduces `pwm_raw` bit for bit.
- R6: Every input reaches the output after exactly three rising clock edges in all modes. A value applied before edge k affects `pwm_out` just after edge k+2.
- R7: `mode_sel` is adopted only on a synchronized rising edge of `win_q`, and it governs that same cycle. A change in the middle of a sample period has no effect until the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_raw | input | 1 | Untrimmed PWM sample stream |
| win_r | input | 1 | Cut-off window for mode 00 (active low) |
| win_s | input | 1 | Cut-off window for mode 01 (active low) |
| win_q | input | 1 | Guard window for mode 00; its rising edge marks a period start |
| win_qn | input | 1 | Guard window for mode 01 |
| mode_sel | input | 2 | 00 trim on Q/R, 01 trim on Q_n/S, 10 or 11 bypass |
| pwm_out | output | 1 | Trimmed and retimed PWM |

## Verification
Every result is due three rising edges after the stimulus that causes it: two synchronizer stages and then the output register. Mode adoption shares that latency because it is decided from the same synchronized Q edge. The bench drives inputs on the falling edge and samples on the next falling edge. It keeps a per-edge history of applied inputs and compares each output against a rule evaluated on the inputs from two edges earlier. The rule is then registered once. For each directed sample period, the bench also counts the output high cycles over a window of the period length. That count is checked against the width the requirements give: the guard width, the clamp value, or the raw width.

// File: rtl/pwm_trim_mask_pkg.sv
package pwm_trim_mask_pkg;

  typedef enum logic [1:0] {
    MODE_TRIM_Q  = 2'b00,
    MODE_TRIM_QN = 2'b01,
    MODE_PASS_A  = 2'b10,
    MODE_PASS_B  = 2'b11
  } mask_mode_t;

  // Input vector positions inside the synchronizer bus
  localparam int unsigned BIT_RAW = 0;
  localparam int unsigned BIT_R   = 1;
  localparam int unsigned BIT_S   = 2;
  localparam int unsigned BIT_Q   = 3;
  localparam int unsigned BIT_QN  = 4;
  localparam int unsigned BIT_SEL = 5;
  localparam int unsigned IN_BITS = 7;

  function automatic logic mode_is_pass(input mask_mode_t m);
    return (m == MODE_PASS_A) || (m == MODE_PASS_B);
  endfunction

  function automatic logic pick_guard(input mask_mode_t m, input logic q, input logic qn);
    return (m == MODE_TRIM_QN) ? qn : q;
  endfunction

  function automatic logic pick_cutoff(input mask_mode_t m, input logic r, input logic s);
    return (m == MODE_TRIM_QN) ? s : r;
  endfunction

  // Guard forces high; otherwise the level may only hold or fall
  function automatic logic trim_next(input logic guard, input logic cutoff,
                                     input logic raw, input logic prev);
    logic nxt;
    if (guard)        nxt = 1'b1;
    else if (!cutoff) nxt = 1'b0;
    else              nxt = prev & raw;
    return nxt;
  endfunction

endpackage

// File: rtl/pwm_mask_sync.sv
module pwm_mask_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pwm_mask_mode.sv
module pwm_mask_mode
  import pwm_trim_mask_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       q_s,
  input  logic [1:0] sel_s,
  output mask_mode_t mode_eff,
  output logic       frame_edge
);

  logic       q_d;
  mask_mode_t act_mode;

  assign frame_edge = q_s & ~q_d;
  assign mode_eff   = frame_edge ? mask_mode_t'(sel_s) : act_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_d      <= 1'b0;
      act_mode <= MODE_TRIM_Q;
    end else begin
      q_d      <= q_s;
      act_mode <= mode_eff;
    end
  end

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff != $past(mode_eff)) |-> frame_edge);

endmodule

// File: rtl/pwm_mask_trim.sv
module pwm_mask_trim
  import pwm_trim_mask_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mask_mode_t mode,
  input  logic       raw_s,
  input  logic       r_s,
  input  logic       s_s,
  input  logic       q_s,
  input  logic       qn_s,
  output logic       pwm_out
);

  logic guard_win;
  logic cutoff_win;
  logic pass_mode;
  logic out_next;

  assign pass_mode  = mode_is_pass(mode);
  assign guard_win  = pick_guard(mode, q_s, qn_s);
  assign cutoff_win = pick_cutoff(mode, r_s, s_s);
  assign out_next   = pass_mode ? raw_s : trim_next(guard_win, cutoff_win, raw_s, pwm_out);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_out <= 1'b0;
    else        pwm_out <= out_next;
  end

  // R2
  guard_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_mode && guard_win) |=> pwm_out);

  // R3
  cutoff_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_mode && !guard_win && !cutoff_win) |=> !pwm_out);

  // R4
  no_late_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_mode && !guard_win && !pwm_out) |=> !pwm_out);

  // R5
  bypass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_mode |=> (pwm_out == $past(raw_s)));

endmodule

// File: rtl/pwm_trim_mask.sv
module pwm_trim_mask
  import pwm_trim_mask_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_raw,
  input  logic       win_r,
  input  logic       win_s,
  input  logic       win_q,
  input  logic       win_qn,
  input  logic [1:0] mode_sel,
  output logic       pwm_out
);

  localparam int unsigned LATENCY = SYNC_STAGES + 1;

  logic [IN_BITS-1:0] in_vec;
  logic [IN_BITS-1:0] in_sync;
  mask_mode_t         mode_eff;
  logic               frame_edge;

  assign in_vec = {mode_sel, win_qn, win_q, win_s, win_r, pwm_raw};

  pwm_mask_sync #(.WIDTH(IN_BITS), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (in_vec),
    .q     (in_sync)
  );

  pwm_mask_mode mode_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_s        (in_sync[BIT_Q]),
    .sel_s      (in_sync[BIT_SEL +: 2]),
    .mode_eff   (mode_eff),
    .frame_edge (frame_edge)
  );

  pwm_mask_trim trim_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_eff),
    .raw_s   (in_sync[BIT_RAW]),
    .r_s     (in_sync[BIT_R]),
    .s_s     (in_sync[BIT_S]),
    .q_s     (in_sync[BIT_Q]),
    .qn_s    (in_sync[BIT_QN]),
    .pwm_out (pwm_out)
  );

  initial begin
    // R6
    latency_param_chk: assert (LATENCY >= 3);
  end

  // R7
  edge_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |=> !frame_edge);

endmodule

// File: tb/pwm_trim_mask_tb_top.sv
`timescale 1ns/1ps
module pwm_trim_mask_tb_top;

  localparam int FRAME = 24;
  localparam int OFS   = 4;
  localparam int HLEN  = 2048;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, pwm_raw, win_r, win_s, win_q, win_qn, pwm_out;
  logic [1:0] mode_sel;

  pwm_trim_mask dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw), .win_r(win_r), .win_s(win_s),
    .win_q(win_q), .win_qn(win_qn), .mode_sel(mode_sel), .pwm_out(pwm_out)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int pe       = 0;
  logic [6:0] hist  [HLEN];
  logic       m_out [HLEN];
  logic [1:0] m_mode[HLEN];

  task automatic chk(input int actual, input int expected, input string tag);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, actual, expected, pe);
    end
  endtask

  // Expected output for edge index i from the stimulus history
  task automatic model_edge(input int i);
    logic [6:0] a, b;
    logic [1:0] md;
    logic g, c, o;
    a = hist[i-2];
    b = hist[i-3];
    if (a[3] && !b[3]) md = a[6:5];
    else               md = m_mode[i-1];
    if (md[1]) o = a[0];
    else begin
      g = md[0] ? a[4] : a[3];
      c = md[0] ? a[2] : a[1];
      o = g | (c & a[0] & m_out[i-1]);
    end
    m_mode[i] = md;
    m_out[i]  = o;
  endtask

  task automatic step(input logic raw, input logic r, input logic s, input logic q,
                      input logic qn, input logic [1:0] sel, input string tag);
    pwm_raw = raw; win_r = r; win_s = s; win_q = q; win_qn = qn; mode_sel = sel;
    hist[pe+1+OFS] = {sel, qn, q, s, r, raw};
    @(posedge clk);
    pe++;
    model_edge(pe + OFS);
    @(negedge clk);
    chk(int'(pwm_out), int'(m_out[pe+OFS]), tag);   // R6 per-edge latency check
  endtask

  // One sample period: Q guard 0..3, Q_n guard 12..15, R and S cut-off from 20
  task automatic run_frame(input logic [1:0] sel_a, input logic [1:0] sel_b, input int sw_at,
                           input logic [FRAME-1:0] pat, input string tag, output int hi);
    hi = 0;
    for (int c = 0; c < FRAME; c++) begin
      step(pat[c], c < 20, c < 20, c < 4, (c >= 12) && (c < 16),
           (c < sw_at) ? sel_a : sel_b, tag);
      hi += int'(pwm_out);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    pwm_raw = 0; win_r = 0; win_s = 0; win_q = 0; win_qn = 0; mode_sel = 0;
    repeat (4) @(negedge clk);
    chk(int'(pwm_out), 0, "R1 reset low");
    rst_n = 1'b1;
    // sel asks for bypass but no Q edge yet: still trim-on-Q, output held low
    for (int c = 0; c < 6; c++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b10, "R1");
    chk(int'(pwm_out), 0, "R1 mode after reset");
  endtask

  task automatic t_trim_q();
    int h;
    run_frame(2'b00, 2'b00, FRAME, 24'h000001, "R2", h);
    run_frame(2'b00, 2'b00, FRAME, 24'h000001, "R2", h);
    chk(h, 4, "R2 short pulse stretched to Q guard");
    run_frame(2'b00, 2'b00, FRAME, 24'h0003FF, "R2", h);
    chk(h, 10, "R2 mid pulse kept");
    run_frame(2'b00, 2'b00, FRAME, 24'h7FFFFF, "R3", h);
    chk(h, 20, "R3 long pulse cut at R");
  endtask

  task automatic t_trim_qn();
    int h;
    run_frame(2'b01, 2'b01, FRAME, 24'h003000, "R2", h);
    run_frame(2'b01, 2'b01, FRAME, 24'h003000, "R2", h);
    chk(h, 4, "R2 short pulse stretched to Q_n guard");
    run_frame(2'b01, 2'b01, FRAME, 24'h03F000, "R2", h);
    chk(h, 6, "R2 mid pulse kept mode 01");
    run_frame(2'b01, 2'b01, FRAME, 24'h7FF000, "R3", h);
    chk(h, 8, "R3 long pulse cut at S");
  endtask

  task automatic t_glitch();
    int h;
    run_frame(2'b00, 2'b00, FRAME, 24'h000400, "R4", h);
    chk(h, 4, "R4 late narrow high suppressed");
    run_frame(2'b00, 2'b00, FRAME, 24'h00FEFF, "R4", h);
    chk(h, 8, "R4 low gap ends pulse");
  endtask

  task automatic t_bypass();
    int h;
    run_frame(2'b10, 2'b10, FRAME, 24'h0A5C3B, "R5", h);
    chk(h, 11, "R5 bypass 10 copies raw");
    run_frame(2'b11, 2'b11, FRAME, 24'h01F00F, "R5", h);
    chk(h, 9, "R5 bypass 11 copies raw");
  endtask

  task automatic t_mode_switch();
    int h;
    run_frame(2'b00, 2'b00, FRAME, 24'h000000, "R7", h);
    run_frame(2'b00, 2'b10, 10, 24'h00403F, "R7", h);
    chk(h, 6, "R7 mid-period switch to bypass deferred");
    run_frame(2'b10, 2'b10, FRAME, 24'h000F00, "R7", h);
    chk(h, 4, "R7 bypass active after Q edge");
    run_frame(2'b10, 2'b00, 10, 24'h004000, "R7", h);
    chk(h, 1, "R7 mid-period switch to trim deferred");
    run_frame(2'b00, 2'b00, FRAME, 24'h000000, "R7", h);
    chk(h, 4, "R7 trim active after Q edge");
  endtask

  initial begin
    for (int i = 0; i < HLEN; i++) begin
      hist[i] = '0; m_out[i] = 1'b0; m_mode[i] = 2'b00;
    end
    t_reset();
    t_trim_q();
    t_trim_qn();
    t_glitch();
    t_bypass();
    t_mode_switch();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule